// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

The controller ranks up to 32 interrupt sources through 16 programmable vector slots. Slot 0 has the highest priority. Below the slots sits one default level that serves any source no enabled slot claims. The combined pending vector, the enable mask and the fast-interrupt select mask come in as plain inputs. The controller drives a normal interrupt line and a fast interrupt line. It also holds the vector addresses and slot control bytes behind a small register strobe interface.

Software takes an interrupt by reading the vector register. The read raises the service level to the winning slot and remembers the level it replaced. It returns the address of the routine to run. Software ends the interrupt by writing the same register, which restores the remembered level. Each level has its own save slot, so interrupts may nest to any depth that the slot ranking allows.

Top module: `vpi_ctrl`

## Requirements
- R1: After reset all slot addresses, slot control bytes and the default address read as zero. The service level is idle, so `irq_o` and `fiq_o` are low while nothing is pending.
- R2: A slot control byte holds the source number in bits 4:0 and the slot enable in bit 5. When it is read back, every other bit is zero.
- R3: Word addresses: 0x00 is the vector register, 0x01 is the default address, 0x10+j is the address of slot j, and 0x20+j is the control byte of slot j. Unmapped addresses read as zero. Read data and `bus_rvalid_o` appear in the cycle after the read strobe.
- R4: While idle, `irq_o` is high exactly when some source is pending, enabled and not selected for fast interrupt.
- R5: While a level L is in service, `irq_o` considers only the sources of enabled slots numbered below L. At the default level, it considers the sources of all enabled slots.
- R6: `fiq_o` is high exactly when some pending source is selected for fast interrupt. A source selected for fast interrupt does not raise `irq_o`.
- R7: A vector read takes the lowest-numbered enabled slot whose source is pending. If that slot is below the current level, the slot becomes the current level and the read returns the slot's address.
- R8: If no enabled slot has a pending source but some source is pending, a vector read from idle moves the controller to the default level and returns the default address.
- R9: A vector read with nothing pending while idle returns the default address and leaves the level idle.
- R10: A vector read whose winner is not below the current level leaves the level unchanged and returns the current level's address.
- R11: A write to the vector register ignores its data and restores the level saved when the current level was entered. While idle, the write has no effect.
- R12: Nested acknowledges unwind in reverse order through successive end-of-interrupt writes, and end back at idle.
- R13: A write to a slot control byte changes the `irq_o` masking from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_SRC | Combined pending sources |
| en_i | input | NUM_SRC | Source enable mask |
| fiq_sel_i | input | NUM_SRC | Fast-interrupt select mask |
| bus_rd_i | input | 1 | Read strobe, one access per cycle |
| bus_wr_i | input | 1 | Write strobe, one access per cycle; takes precedence over a read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the controller with its defaults: 32 sources and 16 slots, which gives 17 ranked levels and the idle state. With these values, source 31 can be bound to a slot, and a three-deep nest can run from idle through the default level and two slots. That nest exposes each save slot on the way back out. The full source width also lets the bench tell a slot-claimed source from an unclaimed one at the default level.

// File: rtl/vpi_pkg.sv
package vpi_pkg;

    localparam int unsigned BUS_AW = 6;

    typedef enum logic [2:0] {
        RK_VECT,
        RK_DEF,
        RK_SLOT_ADDR,
        RK_SLOT_CTRL,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  idx;
    } reg_dec_t;

    function automatic reg_dec_t vpi_decode(input logic [BUS_AW-1:0] a);
        reg_dec_t d;
        d.idx = a[3:0];
        unique case (a[5:4])
            2'd0:    d.kind = (a[3:0] == 4'd0) ? RK_VECT :
                              (a[3:0] == 4'd1) ? RK_DEF  : RK_NONE;
            2'd1:    d.kind = RK_SLOT_ADDR;
            2'd2:    d.kind = RK_SLOT_CTRL;
            default: d.kind = RK_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/vpi_slot_regs.sv
module vpi_slot_regs
    import vpi_pkg::*;
#(
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned SRC_W    = 5,
    parameter int unsigned DW       = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  reg_dec_t                         dec,
    input  logic [DW-1:0]                    wdata,
    output logic [NUM_SLOT-1:0]              slot_en_o,
    output logic [NUM_SLOT-1:0][SRC_W-1:0]   slot_src_o,
    output logic [NUM_SLOT:0][DW-1:0]        vaddr_o
);

    // default address lives at index NUM_SLOT
    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr_o[NUM_SLOT] <= '0;
        end else if (wr_en && dec.kind == RK_DEF) begin
            vaddr_o[NUM_SLOT] <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        logic hit_addr;
        logic hit_ctrl;
        assign hit_addr = wr_en && dec.kind == RK_SLOT_ADDR && int'(dec.idx) == g;
        assign hit_ctrl = wr_en && dec.kind == RK_SLOT_CTRL && int'(dec.idx) == g;

        always_ff @(posedge clk) begin
            if (rst) begin
                vaddr_o[g]    <= '0;
                slot_en_o[g]  <= 1'b0;
                slot_src_o[g] <= '0;
            end else begin
                if (hit_addr) vaddr_o[g] <= wdata;
                if (hit_ctrl) begin
                    slot_en_o[g]  <= wdata[SRC_W];
                    slot_src_o[g] <= wdata[SRC_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/vpi_mask_gen.sv
module vpi_mask_gen #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned SRC_W    = 5
) (
    input  logic [NUM_SLOT-1:0]               slot_en_i,
    input  logic [NUM_SLOT-1:0][SRC_W-1:0]    slot_src_i,
    output logic [NUM_SLOT+1:0][NUM_SRC-1:0]  mask_o
);

    // prefix OR: entry k holds sources of enabled slots numbered below k
    logic [NUM_SLOT:0][NUM_SRC-1:0] pre;

    assign pre[0] = '0;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_pre
        logic [NUM_SRC-1:0] bit_g;
        assign bit_g      = slot_en_i[g] ? (NUM_SRC'(1) << slot_src_i[g]) : '0;
        assign pre[g+1]   = pre[g] | bit_g;
    end

    for (genvar k = 0; k <= NUM_SLOT; k++) begin : g_out
        assign mask_o[k] = pre[k];
    end

    // idle: everything may interrupt
    assign mask_o[NUM_SLOT+1] = '1;

endmodule

// File: rtl/vpi_ack_scan.sv
module vpi_ack_scan #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned SRC_W    = 5,
    parameter int unsigned LVL_W    = 5
) (
    input  logic [NUM_SRC-1:0]              pend_i,
    input  logic [NUM_SLOT-1:0]             slot_en_i,
    input  logic [NUM_SLOT-1:0][SRC_W-1:0]  slot_src_i,
    input  logic [LVL_W-1:0]                cur_i,
    output logic [LVL_W-1:0]                cand_o,
    output logic                            raise_o,
    output logic [LVL_W-1:0]                new_lvl_o
);

    localparam logic [LVL_W-1:0] DEF_L  = LVL_W'(NUM_SLOT);
    localparam logic [LVL_W-1:0] IDLE_L = LVL_W'(NUM_SLOT + 1);

    logic [NUM_SLOT-1:0] hit;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_hit
        assign hit[g] = slot_en_i[g] & pend_i[slot_src_i[g]];
    end

    always_comb begin
        cand_o = (|pend_i) ? DEF_L : IDLE_L;
        for (int j = NUM_SLOT - 1; j >= 0; j--) begin
            if (hit[j]) cand_o = LVL_W'(j);
        end
    end

    assign raise_o   = cand_o < cur_i;
    assign new_lvl_o = raise_o ? cand_o : cur_i;

endmodule

// File: rtl/vpi_level_track.sv
module vpi_level_track #(
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned LVL_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_i,
    input  logic              eoi_i,
    input  logic              raise_i,
    input  logic [LVL_W-1:0]  cand_i,
    output logic [LVL_W-1:0]  cur_o
);

    localparam logic [LVL_W-1:0] IDLE_L = LVL_W'(NUM_SLOT + 1);

    logic [NUM_SLOT:0][LVL_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o  <= IDLE_L;
            prev_q <= {(NUM_SLOT + 1){IDLE_L}};
        end else if (ack_i && raise_i) begin
            prev_q[cand_i] <= cur_o;
            cur_o          <= cand_i;
        end else if (eoi_i && cur_o != IDLE_L) begin
            cur_o <= prev_q[cur_o];
        end
    end

    // R7
    ack_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && raise_i) |=> (cur_o == $past(cand_i)));

    // R10
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !raise_i && !eoi_i) |=> $stable(cur_o));

    // R11
    eoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !ack_i && cur_o == IDLE_L) |=> (cur_o == IDLE_L));

    // R12
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur_o <= IDLE_L);

    // R12
    eoi_only_lowers_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !ack_i) |=> (cur_o >= $past(cur_o)));

endmodule

// File: rtl/vpi_ctrl.sv
module vpi_ctrl
    import vpi_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_SLOT = 16,
    parameter int unsigned DW       = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   pend_i,
    input  logic [NUM_SRC-1:0]   en_i,
    input  logic [NUM_SRC-1:0]   fiq_sel_i,
    input  logic                 bus_rd_i,
    input  logic                 bus_wr_i,
    input  logic [BUS_AW-1:0]    bus_addr_i,
    input  logic [DW-1:0]        bus_wdata_i,
    output logic [DW-1:0]        bus_rdata_o,
    output logic                 bus_rvalid_o,
    output logic                 irq_o,
    output logic                 fiq_o
);

    localparam int unsigned SRC_W  = $clog2(NUM_SRC);
    localparam int unsigned LVL_W  = $clog2(NUM_SLOT + 2);
    localparam logic [LVL_W-1:0] IDLE_L = LVL_W'(NUM_SLOT + 1);
    localparam logic [LVL_W-1:0] DEF_L  = LVL_W'(NUM_SLOT);

    reg_dec_t                         dec;
    logic                             rd_acc;
    logic [NUM_SLOT-1:0]              slot_en;
    logic [NUM_SLOT-1:0][SRC_W-1:0]   slot_src;
    logic [NUM_SLOT:0][DW-1:0]        vaddr;
    logic [NUM_SLOT+1:0][NUM_SRC-1:0] mask;
    logic [LVL_W-1:0]                 cur;
    logic [LVL_W-1:0]                 cand;
    logic [LVL_W-1:0]                 new_lvl;
    logic [LVL_W-1:0]                 ret_idx;
    logic                             raise;
    logic                             ack;
    logic                             eoi;
    logic                             idx_ok;
    logic [DW-1:0]                    rd_val;
    logic [NUM_SRC-1:0]               irq_src;

    assign dec    = vpi_decode(bus_addr_i);
    assign rd_acc = bus_rd_i && !bus_wr_i;
    assign ack    = rd_acc && dec.kind == RK_VECT;
    assign eoi    = bus_wr_i && dec.kind == RK_VECT;
    assign idx_ok = int'(dec.idx) < NUM_SLOT;

    vpi_slot_regs #(.NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W), .DW(DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr_i),
        .dec        (dec),
        .wdata      (bus_wdata_i),
        .slot_en_o  (slot_en),
        .slot_src_o (slot_src),
        .vaddr_o    (vaddr)
    );

    vpi_mask_gen #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W)) u_mask (
        .slot_en_i  (slot_en),
        .slot_src_i (slot_src),
        .mask_o     (mask)
    );

    vpi_ack_scan #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_scan (
        .pend_i     (pend_i),
        .slot_en_i  (slot_en),
        .slot_src_i (slot_src),
        .cur_i      (cur),
        .cand_o     (cand),
        .raise_o    (raise),
        .new_lvl_o  (new_lvl)
    );

    vpi_level_track #(.NUM_SLOT(NUM_SLOT), .LVL_W(LVL_W)) u_lvl (
        .clk     (clk),
        .rst     (rst),
        .ack_i   (ack),
        .eoi_i   (eoi),
        .raise_i (raise),
        .cand_i  (cand),
        .cur_o   (cur)
    );

    // idle maps to the default address on a read
    assign ret_idx = (new_lvl == IDLE_L) ? DEF_L : new_lvl;

    always_comb begin
        rd_val = '0;
        unique case (dec.kind)
            RK_VECT:      rd_val = vaddr[ret_idx];
            RK_DEF:       rd_val = vaddr[NUM_SLOT];
            RK_SLOT_ADDR: if (idx_ok) rd_val = vaddr[dec.idx];
            RK_SLOT_CTRL: if (idx_ok) rd_val = DW'({slot_en[dec.idx], slot_src[dec.idx]});
            default:      rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata_o  <= '0;
            bus_rvalid_o <= 1'b0;
        end else begin
            bus_rvalid_o <= rd_acc;
            if (rd_acc) bus_rdata_o <= rd_val;
        end
    end

    assign irq_src = pend_i & en_i & ~fiq_sel_i;
    assign irq_o   = |(irq_src & mask[cur]);
    assign fiq_o   = |(pend_i & fiq_sel_i);

    // R4
    irq_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> |(pend_i & en_i & ~fiq_sel_i));

    // R6
    fiq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fiq_sel_i == '0) |-> !fiq_o);

    // R3
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && !bus_wr_i) |=> bus_rvalid_o);

    // R3
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_i |=> !bus_rvalid_o);

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/vpi_ctrl_tb_top.sv
module vpi_ctrl_tb_top;

    localparam int unsigned NSRC = 32;
    localparam int unsigned DW   = 32;

    localparam logic [5:0] A_VECT = 6'h00;
    localparam logic [5:0] A_DEF  = 6'h01;

    logic            clk = 1'b0;
    logic            rst;
    logic [NSRC-1:0] pend, en, fsel;
    logic            rd, wr;
    logic [5:0]      addr;
    logic [DW-1:0]   wdata;
    logic [DW-1:0]   rdata;
    logic            rvalid;
    logic            irq, fiq;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    vpi_ctrl #(.NUM_SRC(NSRC), .NUM_SLOT(16), .DW(DW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .pend_i       (pend),
        .en_i         (en),
        .fiq_sel_i    (fsel),
        .bus_rd_i     (rd),
        .bus_wr_i     (wr),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .irq_o        (irq),
        .fiq_o        (fiq)
    );

    // monitor: pop expected read data as results appear
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R3 unexpected read data act=%h exp=none", rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    bad++;
                    $display("FAIL %s read act=%h exp=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic set_pend(input logic [NSRC-1:0] v);
        @(negedge clk);
        pend = v;
    endtask

    task automatic chk_irq(input logic e, input string t);
        #1;
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s irq act=%b exp=%b", t, irq, e);
        end
    endtask

    task automatic chk_fiq(input logic e, input string t);
        #1;
        total++;
        if (fiq !== e) begin
            bad++;
            $display("FAIL %s fiq act=%b exp=%b", t, fiq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; pend = '0; en = '0; fsel = '0;
        rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1");
        chk_fiq(1'b0, "R1");
        bus_read(A_DEF, 32'h0, "R1");
        bus_read(6'h13, 32'h0, "R1");
        bus_read(6'h23, 32'h0, "R1");
        bus_read(A_VECT, 32'h0, "R9");

        en = '1;
        bus_write(6'h20, 32'h25);
        bus_write(6'h10, 32'h1000);
        bus_write(6'h23, 32'hE9);
        bus_write(6'h13, 32'h1300);
        bus_write(6'h27, 32'h3F);
        bus_write(6'h17, 32'h1700);
        bus_write(A_DEF, 32'hD000);

        // R2 / R3 readback and map
        bus_read(6'h23, 32'h29, "R2");
        bus_read(6'h27, 32'h3F, "R2");
        bus_read(6'h13, 32'h1300, "R3");
        bus_read(6'h3F, 32'h0, "R3");

        // R4 idle masking
        set_pend(32'h1 << 20);
        chk_irq(1'b1, "R4");
        chk_fiq(1'b0, "R6");
        @(negedge clk); en[20] = 1'b0;
        chk_irq(1'b0, "R4");
        @(negedge clk); en[20] = 1'b1;

        // R6 fast interrupt routing
        @(negedge clk); fsel = 32'h1 << 20;
        chk_irq(1'b0, "R6");
        chk_fiq(1'b1, "R6");
        @(negedge clk); fsel = '0;

        // R8 unclaimed source goes to default level
        bus_read(A_VECT, 32'hD000, "R8");
        chk_irq(1'b0, "R5");

        // R5 / R7 slot 3 outranks default level
        set_pend(pend | (32'h1 << 9));
        chk_irq(1'b1, "R5");
        bus_read(A_VECT, 32'h1300, "R7");
        chk_irq(1'b0, "R5");

        // lower slot 7 (source 31) cannot interrupt level 3
        set_pend(pend | (32'h1 << 31));
        chk_irq(1'b0, "R5");
        bus_read(A_VECT, 32'h1300, "R10");

        // slot 0 nests on top
        set_pend(pend | (32'h1 << 5));
        chk_irq(1'b1, "R5");
        bus_read(A_VECT, 32'h1000, "R7");
        chk_irq(1'b0, "R5");

        // R11 / R12 unwind
        bus_write(A_VECT, 32'hFFFF_FFFF);
        chk_irq(1'b1, "R11");
        set_pend(pend & ~(32'h1 << 5));
        chk_irq(1'b0, "R12");
        bus_read(A_VECT, 32'h1300, "R12");
        bus_read(A_DEF, 32'hD000, "R11");
        bus_write(A_VECT, 32'h0);
        chk_irq(1'b1, "R12");
        bus_write(A_VECT, 32'h0);
        set_pend(32'h1 << 20);
        chk_irq(1'b1, "R12");

        // R11 end-of-interrupt while idle
        bus_write(A_VECT, 32'h1234);
        chk_irq(1'b1, "R11");
        bus_read(A_VECT, 32'hD000, "R11");
        chk_irq(1'b0, "R5");

        // R13 new slot claims source 20
        bus_write(6'h25, 32'h34);
        chk_irq(1'b1, "R13");
        bus_write(6'h15, 32'h1500);
        bus_read(A_VECT, 32'h1500, "R7");
        chk_irq(1'b0, "R5");
        bus_write(6'h25, 32'h14);
        bus_write(A_VECT, 32'h0);
        chk_irq(1'b0, "R13");
        bus_write(A_VECT, 32'h0);
        chk_irq(1'b1, "R12");

        // R9 nothing pending while idle
        set_pend('0);
        bus_read(A_VECT, 32'hD000, "R9");
        set_pend(32'h1 << 20);
        chk_irq(1'b1, "R9");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R3 missing reads act=%0d exp=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule